// File: doc/BRIEF.md
# Interrupt Pending Register Unit

This block keeps one pending flag per interrupt line and merges every source that can change those flags into a single update each clock cycle. Software raises flags through a set port and lowers them through a clear port, each qualified by a strobe and carrying a bit mask. Hardware request lines are either level type, where the flag follows the line, or edge type, where a rising edge latches the flag. Each timer compare unit can send a one-cycle pulse that lowers only the flag of its own timer line.

Every source that acts in a cycle feeds one next-state computation, so a hardware edge, a software write and a timer clear that coincide are all applied together. When one of them sets a bit and another clears it, the set wins. The unit outputs the raw pending vector. It also outputs that vector masked by a software-written enable register. The non-maskable line ignores the enable, and the clear port cannot lower it.

Top module: `irq_pend_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the pending vector and the enable register are cleared, so both outputs read zero after that edge.
- R2: A level-type line (a bit set in `LEVEL_MASK`, lines 0 to 3 by default) shows the value its request input had at the previous clock edge. The set port, the clear port and the timer pulses have no effect on it.
- R3: On an edge-type line, a set-port write (`sw_set_en` high) sets every bit of `sw_set_mask` and never clears any pending bit.
- R4: A clear-port write (`sw_clr_en` high) clears the edge-type bits given in `sw_clr_mask`, except the non-maskable line (`NMI_LINE`, 15 by default), which keeps its value.
- R5: An edge-type line whose request input goes from 0 to 1 between two clock edges becomes pending at the second edge. It stays pending after the input falls, until it is cleared.
- R6: A pulse on `tmr_clr[j]` clears only the line assigned to timer j (line 6 for timer 0 and line 10 for timer 1 by default) and leaves every other bit unchanged.
- R7: When a set (set port or rising edge) and a clear (clear port or timer pulse) hit the same edge-type bit in one cycle, the bit is pending afterwards.
- R8: A cycle with `en_wr` high loads `en_data` into the enable register. `irq_enabled` equals `irq_pending` ANDed with the enable register, except that the non-maskable bit passes whether or not it is enabled.
- R9: Hardware edges, software set and clear writes and timer pulses that arrive in the same cycle are all applied in that cycle's single update, and none of them is lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_set_en | input | 1 | Set-port write strobe |
| sw_set_mask | input | N | Bits to set |
| sw_clr_en | input | 1 | Clear-port write strobe |
| sw_clr_mask | input | N | Bits to clear |
| hw_irq | input | N | Hardware interrupt request lines |
| tmr_clr | input | NUM_TMR | One clear pulse per timer compare unit |
| en_wr | input | 1 | Enable register write strobe |
| en_data | input | N | New enable register value |
| irq_pending | output | N | Pending vector |
| irq_enabled | output | N | Pending vector masked by the enable register |

## Verification
The hardest case to reach from the ports is a cycle in which one bit is set and cleared at once, and the two requests come from different sources: a rising edge against a clear-port write, or a set-port write against a timer pulse. Such cycles must also occur while other sources are acting on other bits. Directed steps first build exact collisions of this kind on the timer lines and on a plain edge line. After that, long random runs with dense set, clear and timer masks produce many more coincidences, and a bench model checks every cycle.

// File: rtl/irqp_pkg.sv
package irqp_pkg;

    // Width of one entry in a packed list of line indices
    localparam int unsigned LINE_IDX_W = 8;

    typedef enum logic {
        TRIG_EDGE  = 1'b0,
        TRIG_LEVEL = 1'b1
    } trig_e;

    // Per-line update request after all sources are merged
    typedef struct packed {
        logic set_req;
        logic clr_req;
        logic hw_level;
    } bit_upd_t;

    // One-hot vector with bit idx set, wide enough for any line index
    function automatic logic [255:0] line_onehot(input logic [LINE_IDX_W-1:0] idx);
        logic [255:0] v;
        v = '0;
        v[idx] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/irqp_edge_det.sv
module irqp_edge_det #(
    parameter int unsigned N = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] lines,
    output logic [N-1:0] rise
);
    logic [N-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= lines;
    end

    assign rise = lines & ~prev_q;
endmodule

// File: rtl/irqp_pend_cell.sv
module irqp_pend_cell
    import irqp_pkg::*;
#(
    parameter trig_e TRIG = TRIG_EDGE
) (
    input  logic     clk,
    input  logic     rst,
    input  bit_upd_t upd,
    output logic     pend
);
    generate
        if (TRIG == TRIG_LEVEL) begin : g_level
            always_ff @(posedge clk) begin
                if (rst) pend <= 1'b0;
                else     pend <= upd.hw_level;
            end
        end else begin : g_edge
            always_ff @(posedge clk) begin
                if (rst) pend <= 1'b0;
                else     pend <= upd.set_req | (pend & ~upd.clr_req);
            end
        end
    endgenerate
endmodule

// File: rtl/irqp_enable_reg.sv
module irqp_enable_reg #(
    parameter int unsigned N = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] en_q
);
    always_ff @(posedge clk) begin
        if (rst)     en_q <= '0;
        else if (wr) en_q <= wdata;
    end
endmodule

// File: rtl/irq_pend_unit.sv
module irq_pend_unit
    import irqp_pkg::*;
#(
    parameter int unsigned N          = 16,
    parameter int unsigned NMI_LINE   = 15,
    parameter int unsigned NUM_TMR    = 2,
    parameter logic [N-1:0] LEVEL_MASK = 16'h000F,
    parameter logic [NUM_TMR*LINE_IDX_W-1:0] TMR_LINES = {8'd10, 8'd6}
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sw_set_en,
    input  logic [N-1:0]       sw_set_mask,
    input  logic               sw_clr_en,
    input  logic [N-1:0]       sw_clr_mask,
    input  logic [N-1:0]       hw_irq,
    input  logic [NUM_TMR-1:0] tmr_clr,
    input  logic               en_wr,
    input  logic [N-1:0]       en_data,
    output logic [N-1:0]       irq_pending,
    output logic [N-1:0]       irq_enabled
);
    localparam logic [N-1:0] NMI_BIT = {{(N-1){1'b0}}, 1'b1} << NMI_LINE;

    logic [N-1:0] hw_rise;
    logic [N-1:0] tmr_clr_vec;
    logic [N-1:0] set_vec;
    logic [N-1:0] clr_vec;
    logic [N-1:0] enable_q;

    irqp_edge_det #(.N(N)) u_edge (
        .clk  (clk),
        .rst  (rst),
        .lines(hw_irq),
        .rise (hw_rise)
    );

    // Each timer clears its own line only
    always_comb begin
        tmr_clr_vec = '0;
        for (int j = 0; j < int'(NUM_TMR); j++) begin
            if (tmr_clr[j]) begin
                tmr_clr_vec = tmr_clr_vec
                    | line_onehot(TMR_LINES[j*LINE_IDX_W +: LINE_IDX_W])[N-1:0];
            end
        end
    end

    // Merge all sources; the clear port never reaches the NMI bit
    always_comb begin
        set_vec = hw_rise | (sw_set_en ? sw_set_mask : '0);
        clr_vec = tmr_clr_vec | (sw_clr_en ? (sw_clr_mask & ~NMI_BIT) : '0);
    end

    generate
        for (genvar i = 0; i < int'(N); i++) begin : g_line
            bit_upd_t upd;
            assign upd.set_req  = set_vec[i];
            assign upd.clr_req  = clr_vec[i];
            assign upd.hw_level = hw_irq[i];

            irqp_pend_cell #(
                .TRIG(LEVEL_MASK[i] ? TRIG_LEVEL : TRIG_EDGE)
            ) u_cell (
                .clk (clk),
                .rst (rst),
                .upd (upd),
                .pend(irq_pending[i])
            );
        end
    endgenerate

    irqp_enable_reg #(.N(N)) u_en (
        .clk  (clk),
        .rst  (rst),
        .wr   (en_wr),
        .wdata(en_data),
        .en_q (enable_q)
    );

    assign irq_enabled = irq_pending & (enable_q | NMI_BIT);
endmodule

// File: rtl/irqp_checker.sv
module irqp_checker #(
    parameter int unsigned N          = 16,
    parameter int unsigned NMI_LINE   = 15,
    parameter logic [N-1:0] LEVEL_MASK = 16'h000F
) (
    input logic         clk,
    input logic         rst,
    input logic         sw_set_en,
    input logic [N-1:0] sw_set_mask,
    input logic [N-1:0] hw_irq,
    input logic [N-1:0] irq_pending,
    input logic [N-1:0] irq_enabled
);
    localparam logic [N-1:0] EDGE_MASK = ~LEVEL_MASK;

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (irq_pending == '0));

    // R2
    level_follows_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((irq_pending & LEVEL_MASK) == ($past(hw_irq) & LEVEL_MASK)));

    // R3
    set_never_clears_chk: assert property (@(posedge clk) disable iff (rst)
        sw_set_en |=> ((irq_pending & $past(sw_set_mask) & EDGE_MASK)
                       == ($past(sw_set_mask) & EDGE_MASK)));

    // R4
    nmi_held_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_pending[NMI_LINE] && EDGE_MASK[NMI_LINE]) |=> irq_pending[NMI_LINE]);

    // R8
    enabled_subset_chk: assert property (@(posedge clk) disable iff (rst)
        ((irq_enabled & ~irq_pending) == '0)
        && (irq_enabled[NMI_LINE] == irq_pending[NMI_LINE]));
endmodule

bind irq_pend_unit irqp_checker #(
    .N(N), .NMI_LINE(NMI_LINE), .LEVEL_MASK(LEVEL_MASK)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .sw_set_en  (sw_set_en),
    .sw_set_mask(sw_set_mask),
    .hw_irq     (hw_irq),
    .irq_pending(irq_pending),
    .irq_enabled(irq_enabled)
);

// File: tb/tb_irq_pend_unit.sv
module tb_irq_pend_unit;
    localparam int N = 16;
    localparam int NMI = 15;
    localparam int T = 2;
    localparam logic [N-1:0] LVL = 16'h000F;
    localparam int TL0 = 6;
    localparam int TL1 = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sw_set_en = 0, sw_clr_en = 0, en_wr = 0;
    logic [N-1:0] sw_set_mask = '0, sw_clr_mask = '0, hw_irq = '0, en_data = '0;
    logic [T-1:0] tmr_clr = '0;
    logic [N-1:0] irq_pending, irq_enabled;

    int checks = 0, fails = 0;
    logic [N-1:0] m_pend = '0, m_prev = '0, m_en = '0;

    always #2.5 clk = ~clk;

    irq_pend_unit dut (
        .clk(clk), .rst(rst),
        .sw_set_en(sw_set_en), .sw_set_mask(sw_set_mask),
        .sw_clr_en(sw_clr_en), .sw_clr_mask(sw_clr_mask),
        .hw_irq(hw_irq), .tmr_clr(tmr_clr),
        .en_wr(en_wr), .en_data(en_data),
        .irq_pending(irq_pending), .irq_enabled(irq_enabled)
    );

    function automatic logic [N-1:0] model_next(input logic [N-1:0] cur);
        logic [N-1:0] nx;
        for (int i = 0; i < N; i++) begin
            if (LVL[i]) nx[i] = hw_irq[i];
            else begin
                logic s, c;
                s = (sw_set_en & sw_set_mask[i]) | (hw_irq[i] & ~m_prev[i]);
                c = (sw_clr_en & sw_clr_mask[i] & (i != NMI))
                    | (tmr_clr[0] & (i == TL0)) | (tmr_clr[1] & (i == TL1));
                nx[i] = s | (cur[i] & ~c);
            end
        end
        return nx;
    endfunction

    task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(input string tag);
        @(posedge clk);
        m_pend = model_next(m_pend);
        m_prev = hw_irq;
        if (en_wr) m_en = en_data;
        #1;
        check({tag, " pending"}, irq_pending, m_pend);
        check({tag, " enabled"}, irq_enabled, m_pend & (m_en | 16'h8000));
    endtask

    task automatic idle();
        sw_set_en = 0; sw_clr_en = 0; en_wr = 0; tmr_clr = '0;
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1;
        @(posedge clk); @(posedge clk); #1;
        check("R1 reset pending", irq_pending, '0);
        check("R1 reset enabled", irq_enabled, '0);
        rst = 0;

        // R3: set edge bits, then a set write never clears
        sw_set_en = 1; sw_set_mask = 16'hFFF0; cyc("R3 set");
        check("R3 set value", irq_pending, 16'hFFF0);
        sw_set_mask = 16'h0001; cyc("R3 no clear");
        check("R2 level ignores set", irq_pending, 16'hFFF0);
        idle();
        // R4: clear all, NMI survives
        sw_clr_en = 1; sw_clr_mask = 16'hFFFF; cyc("R4 clear");
        check("R4 nmi kept", irq_pending, 16'h8000);
        // R2/R5: level lines follow, edge line latches
        hw_irq = 16'h0105; sw_clr_mask = 16'h000F; cyc("R2 level");
        check("R2 level value", irq_pending, 16'h8105);
        idle(); hw_irq = 16'h0000; cyc("R5 hold");
        check("R5 edge held", irq_pending, 16'h8100);
        // R6: timer clear affects own line only
        sw_set_en = 1; sw_set_mask = 16'h0440; cyc("R6 prep");
        idle(); tmr_clr = 2'b01; cyc("R6 timer");
        check("R6 timer0 only", irq_pending, 16'h8500);
        // R7: set beats clear on same bit
        idle(); sw_set_en = 1; sw_set_mask = 16'h1400;
        sw_clr_en = 1; sw_clr_mask = 16'h1000; tmr_clr = 2'b10; cyc("R7 collide");
        check("R7 set wins", irq_pending, 16'h9500);
        // R8: enable masking, NMI bypass
        idle(); en_wr = 1; en_data = 16'h0100; cyc("R8 enable");
        check("R8 masked", irq_enabled, 16'h8100);
        // R9: all sources in one cycle
        idle(); hw_irq = 16'h0200; sw_set_en = 1; sw_set_mask = 16'h0010;
        sw_clr_en = 1; sw_clr_mask = 16'h0100; cyc("R9 merge");
        check("R9 merged", irq_pending, 16'h9610);
        // R7: rising edge against clear port on same bit
        idle(); hw_irq = 16'h0000; cyc("R7 prep");
        hw_irq = 16'h0800; sw_clr_en = 1; sw_clr_mask = 16'h0800; cyc("R7 edge wins");
        check("R7 edge vs clear", irq_pending[11], 1'b1);

        // R9: random mix against the model
        for (int k = 0; k < 4000; k++) begin
            sw_set_en   = ($urandom % 3) == 0;
            sw_set_mask = N'($urandom) & N'($urandom);
            sw_clr_en   = ($urandom % 2) == 0;
            sw_clr_mask = N'($urandom);
            hw_irq      = N'($urandom) & N'($urandom);
            tmr_clr     = T'($urandom);
            en_wr       = ($urandom % 8) == 0;
            en_data     = N'($urandom);
            cyc("R9 random");
        end
        idle();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule